// File: doc/BRIEF.md
# Chopped Sinc3 Decimation Filter

This block turns the one-bit output of a sigma-delta modulator into signed 24-bit conversion words. The analog front end reverses its input polarity on command from `chop_out`. Each incoming bit is first XORed with the current chop state, which undoes that reversal. A filter bit of 1 counts as +1 and a filter bit of 0 counts as -1. The result goes through a three-stage integrator-comb (sinc3) decimator with ratio R = 8 × SF, where SF is an 8-bit rate word.

A conversion spans three decimation periods, or 24 × SF accepted bits. Only the third decimated sample is kept. It is the first sample whose window lies wholly inside the current chop state. `chop_out` then flips. A constant offset leaves the filter with the opposite sign in successive conversions. The block emits the mean of the two most recent kept samples, so that offset cancels. Writing the rate word restarts the filter and clears the averaging history. A result appears only after two conversions have completed.

The bitstream arrives as a valid-qualified stream: `mod_en` marks each accepted bit and there is no ready signal. The modulator is never stalled. Results leave as a one-clock `res_valid` strobe and there is no back-pressure. A consumer must take `res_data` in the strobe cycle, or within the 24 × SF accepted bits before the next result. When `rate_wr` and `mod_en` are both high in the same cycle, the write wins and that bit is dropped.

Top module: `sdchop_sinc3_dec`

## Requirements
- R1: After reset, `res_valid`, `settled` and `chop_out` are 0 and the rate word is 69. The first result therefore follows 3312 accepted bits.
- R2: The filter input is `mod_bit` XOR `chop_out`, with 1 weighted +1 and 0 weighted -1.
- R3: After the first result, results follow every 24 × SF accepted bits. `chop_out` flips at the end of every conversion, so successive results see opposite chop states. `res_valid` is high for exactly one clock, in the clock after the edge that accepts the last bit of the conversion.
- R4: A rate write with a value below 13 stores 13. Values from 13 to 255 are stored as written.
- R5: A rate write clears the filter, the averaging history, `res_valid` and `settled` by the next clock. The first result then follows exactly 48 × SF accepted bits.
- R6: Let K be the kept third decimated sample. For a filter input of period 8 with d ones, K = (2d − 8) × (8·SF)³ / 8. The output is floor((K_now + K_prev) / 2048) as a signed 24-bit value.
- R7: A constant offset that the front end does not chop is cancelled. If `mod_bit` ignores `chop_out`, every result is 0.
- R8: `settled` rises together with the first `res_valid` after reset or a write, and it stays high until the next write.
- R9: `mod_bit` in cycles without `mod_en`, and `rate_wdata` in cycles without `rate_wr`, have no effect.
- R10: After a step in the filter input that is aligned to a conversion boundary, the next result is the mean of the old and new levels. The one after it fully reflects the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Accepts `mod_bit` in this cycle |
| mod_bit | input | 1 | Modulator output bit |
| rate_wr | input | 1 | Writes the rate word |
| rate_wdata | input | 8 | Rate word SF |
| chop_out | output | 1 | Chop state driven to the front end |
| res_data | output | 24 | Signed averaged conversion word |
| res_valid | output | 1 | One-clock strobe for `res_data` |
| settled | output | 1 | Two conversions have completed since reset or the last write |

## Verification
Every result is due one clock after the edge that accepts the final bit of its conversion. The first result after a write follows 48 × SF accepted bits, and each later one follows another 24 × SF. The bench asserts `mod_en` only on alternate clocks and counts the bits it issues. It samples on the falling edge, which lets it record the bit count at each strobe without racing the driver, and it compares that count against these totals. Expected words come from the R6 closed form for period-8 inputs. The bench changes input levels only in the idle cycle after a strobe, so each step falls exactly on a conversion boundary.

// File: rtl/sdchop_pkg.sv
package sdchop_pkg;
  // the decimation ratio is the rate word times 2**DEC_MUL_LOG2
  localparam int DEC_MUL_LOG2 = 3;
  localparam int DEF_SF_W     = 8;
  localparam int DEF_N_STAGE  = 3;
  localparam int DEF_OUT_W    = 24;
  localparam int DEF_SF_MIN   = 13;
  localparam int DEF_SF_RST   = 69;

  // worst case gain (2**mul_log2 * (2**sf_w - 1))**n_stage plus a sign bit
  function automatic int acc_width(input int sf_w, input int n_stage);
    return n_stage * (DEC_MUL_LOG2 + sf_w) + 1;
  endfunction
endpackage

// File: rtl/sdchop_integ.sv
module sdchop_integ #(
  parameter int ACC_W   = 34,
  parameter int N_STAGE = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    tick,
  input  logic                    x_pos,
  output logic signed [ACC_W-1:0] int_next
);
  logic signed [ACC_W-1:0] acc_q [N_STAGE];
  logic signed [ACC_W-1:0] sum   [N_STAGE+1];

  // +1 for a one, -1 for a zero
  assign sum[0] = x_pos ? {{(ACC_W-1){1'b0}}, 1'b1} : {ACC_W{1'b1}};

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    assign sum[g+1] = acc_q[g] + sum[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q[g] <= '0;
      else if (clr)   acc_q[g] <= '0;
      else if (tick)  acc_q[g] <= sum[g+1];
    end
  end

  assign int_next = sum[N_STAGE];
endmodule

// File: rtl/sdchop_comb.sv
module sdchop_comb #(
  parameter int ACC_W   = 34,
  parameter int N_STAGE = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    stb,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] dly_q [N_STAGE];
  logic signed [ACC_W-1:0] diff  [N_STAGE+1];

  assign diff[0] = din;

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    assign diff[g+1] = diff[g] - dly_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dly_q[g] <= '0;
      else if (clr)  dly_q[g] <= '0;
      else if (stb)  dly_q[g] <= diff[g];
    end
  end

  assign dout = diff[N_STAGE];
endmodule

// File: rtl/sdchop_seq.sv
module sdchop_seq #(
  parameter int SF_W     = 8,
  parameter int MUL_LOG2 = 3,
  parameter int N_PH     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [SF_W-1:0] sf,
  output logic            dec_stb,
  output logic            conv_end,
  output logic            chop
);
  localparam int CNT_W = SF_W + MUL_LOG2;
  localparam int PH_W  = (N_PH > 1) ? $clog2(N_PH) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] cnt_last;

  assign cnt_last = {sf, {MUL_LOG2{1'b0}}} - CNT_W'(1);
  assign dec_stb  = tick && (cnt_q == cnt_last);
  assign conv_end = dec_stb && (ph_q == PH_W'(N_PH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (tick) begin
      if (cnt_q == cnt_last) begin
        cnt_q <= '0;
        ph_q  <= (ph_q == PH_W'(N_PH - 1)) ? '0 : ph_q + PH_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // chop state is not touched by a rate write; it only follows conversions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chop <= 1'b0;
    else if (conv_end) chop <= ~chop;
  end
endmodule

// File: rtl/sdchop_sinc3_dec.sv
module sdchop_sinc3_dec
  import sdchop_pkg::*;
#(
  parameter int SF_W    = DEF_SF_W,
  parameter int N_STAGE = DEF_N_STAGE,
  parameter int OUT_W   = DEF_OUT_W,
  parameter int SF_MIN  = DEF_SF_MIN,
  parameter int SF_RST  = DEF_SF_RST
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en,
  input  logic                    mod_bit,
  input  logic                    rate_wr,
  input  logic [SF_W-1:0]         rate_wdata,
  output logic                    chop_out,
  output logic signed [OUT_W-1:0] res_data,
  output logic                    res_valid,
  output logic                    settled
);
  localparam int ACC_W = acc_width(SF_W, N_STAGE);
  localparam int SUM_W = ACC_W + 1;

  logic [SF_W-1:0]         sf_q;
  logic                    tick, clr;
  logic                    dec_stb, conv_end;
  logic signed [ACC_W-1:0] int_out, comb_out, prev_q;
  logic                    hist_q;
  logic signed [SUM_W-1:0] pair_sum;

  assign clr  = rate_wr;
  assign tick = mod_en && !rate_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sf_q <= SF_W'(SF_RST);
    else if (rate_wr)
      sf_q <= (rate_wdata < SF_W'(SF_MIN)) ? SF_W'(SF_MIN) : rate_wdata;
  end

  sdchop_seq #(.SF_W(SF_W), .MUL_LOG2(DEC_MUL_LOG2), .N_PH(N_STAGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .sf(sf_q),
    .dec_stb(dec_stb), .conv_end(conv_end), .chop(chop_out)
  );

  sdchop_integ #(.ACC_W(ACC_W), .N_STAGE(N_STAGE)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .x_pos(mod_bit ^ chop_out), .int_next(int_out)
  );

  sdchop_comb #(.ACC_W(ACC_W), .N_STAGE(N_STAGE)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stb(dec_stb),
    .din(int_out), .dout(comb_out)
  );

  // mean of this conversion and the previous one, floor via dropped low bits
  assign pair_sum = $signed({comb_out[ACC_W-1], comb_out}) + $signed({prev_q[ACC_W-1], prev_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      hist_q    <= 1'b0;
      res_data  <= '0;
      res_valid <= 1'b0;
      settled   <= 1'b0;
    end else if (clr) begin
      prev_q    <= '0;
      hist_q    <= 1'b0;
      res_valid <= 1'b0;
      settled   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (conv_end) begin
        prev_q    <= comb_out;
        hist_q    <= 1'b1;
        res_data  <= pair_sum[SUM_W-1 -: OUT_W];
        res_valid <= hist_q;
        settled   <= settled | hist_q;
      end
    end
  end
endmodule

// File: rtl/sdchop_sinc3_dec_chk.sv
module sdchop_sinc3_dec_chk #(
  parameter int SF_W   = 8,
  parameter int SF_MIN = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rate_wr,
  input logic [SF_W-1:0] rate_wdata,
  input logic [SF_W-1:0] sf_q,
  input logic            res_valid,
  input logic            settled,
  input logic            chop_out
);
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r3_chop_flipped: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (chop_out != $past(chop_out)));

  a_r4_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_wr && rate_wdata < SF_W'(SF_MIN)) |=> (sf_q == SF_W'(SF_MIN)));

  a_r4_rate_floor: assert property (@(posedge clk) disable iff (!rst_n)
    sf_q >= SF_W'(SF_MIN));

  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> (!settled && !res_valid));

  a_r8_valid_settled: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> settled);

  a_r8_settled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settled) |-> $past(rate_wr));
endmodule

bind sdchop_sinc3_dec sdchop_sinc3_dec_chk #(.SF_W(SF_W), .SF_MIN(SF_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
  .sf_q(sf_q), .res_valid(res_valid), .settled(settled), .chop_out(chop_out)
);

// File: tb/sdchop_sinc3_dec_bench.sv
module sdchop_sinc3_dec_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               mod_en = 1'b0;
  logic               mod_bit = 1'b0;
  logic               rate_wr = 1'b0;
  logic [7:0]         rate_wdata = 8'd0;
  logic               chop_out;
  logic signed [23:0] res_data;
  logic               res_valid;
  logic               settled;

  sdchop_sinc3_dec u_sdchop_sinc3_dec (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
    .rate_wr(rate_wr), .rate_wdata(rate_wdata), .chop_out(chop_out),
    .res_data(res_data), .res_valid(res_valid), .settled(settled)
  );

  always #2.5 clk = ~clk;

  int     n_chk = 0, n_fail = 0;
  bit     run = 0, chopmode = 1, noise = 0, slot = 0;
  int     dens = 8, idx = 0, tick_cnt = 0, nres = 0;
  longint res_val [16];
  int     res_tick[16];
  bit     res_chop[16];

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // R6 closed form
  function automatic longint kval(input int sf, input int d);
    longint r = 8 * sf;
    return (2 * d - 8) * r * r * r / 8;
  endfunction
  function automatic longint expv(input int sf, input int d_now, input int d_prev);
    return (kval(sf, d_now) + kval(sf, d_prev)) >>> 11;
  endfunction

  task automatic driver();
    forever @(negedge clk) begin
      slot = !slot;
      if (run && slot) begin
        mod_en  = 1'b1;
        mod_bit = ((idx % 8) < dens) ^ (chopmode ? chop_out : 1'b0);
        idx++;
        tick_cnt++;
      end else begin
        mod_en  = 1'b0;
        mod_bit = noise ? 1'($urandom) : 1'b0;
        if (noise) rate_wdata = 8'($urandom);
      end
    end
  endtask

  task automatic monitor();
    forever @(negedge clk) begin
      if (res_valid && rst_n && nres < 16) begin
        res_val[nres]  = longint'(res_data);
        res_tick[nres] = tick_cnt;
        res_chop[nres] = chop_out;
        nres++;
      end
    end
  endtask

  task automatic wr_rate(input int v);
    @(negedge clk); run = 0;
    @(negedge clk); rate_wr = 1'b1; rate_wdata = 8'(v);
    @(negedge clk); rate_wr = 1'b0;
    tick_cnt = 0; nres = 0; idx = 0; run = 1;
    chk("R5 settled cleared by write", longint'(settled), 0);
  endtask

  task automatic wait_res(input int n);
    wait (nres >= n);
  endtask

  task automatic t_reset();
    chk("R1 res_valid at reset", longint'(res_valid), 0);
    chk("R1 settled at reset", longint'(settled), 0);
    chk("R1 chop_out at reset", longint'(chop_out), 0);
    dens = 8; chopmode = 1; tick_cnt = 0; nres = 0; idx = 0; run = 1;
    wait_res(1);
    chk("R1 first result after 48*69 bits", res_tick[0], 3312);
    chk("R6 value at default rate", res_val[0], expv(69, 8, 8));
    chk("R8 settled with first result", longint'(settled), 1);
  endtask

  task automatic t_clamp();
    dens = 8; chopmode = 1;
    wr_rate(5);
    wait_res(1);
    chk("R4 write 5 clamps to 13", res_tick[0], 48 * 13);
    chk("R6 value at rate 13", res_val[0], expv(13, 8, 8));
  endtask

  task automatic t_max();
    dens = 0; chopmode = 1;
    wr_rate(255);
    wait_res(1);
    chk("R4 rate 255 accepted", res_tick[0], 48 * 255);
    chk("R6 negative full scale at 255", res_val[0], expv(255, 0, 0));
  endtask

  task automatic t_density(input int d);
    dens = d; chopmode = 1;
    wr_rate(20);
    wait_res(3);
    chk("R5 first result after 48*SF", res_tick[0], 48 * 20);
    for (int i = 0; i < 3; i++)
      chk("R2 R6 dechopped level", res_val[i], expv(20, d, d));
    for (int i = 1; i < 3; i++) begin
      chk("R3 result spacing 24*SF", res_tick[i] - res_tick[i-1], 24 * 20);
      chk("R3 chop alternates", longint'(res_chop[i]), longint'(!res_chop[i-1]));
    end
  endtask

  task automatic t_offset(input int d);
    dens = d; chopmode = 0;
    wr_rate(13);
    wait_res(3);
    for (int i = 0; i < 3; i++)
      chk("R7 unchopped offset cancels", res_val[i], 0);
    chopmode = 1;
  endtask

  task automatic t_step();
    dens = 8; chopmode = 1;
    wr_rate(13);
    wait_res(2);
    dens = 0;
    wait_res(4);
    chk("R10 first result after step is midpoint", res_val[2], expv(13, 0, 8));
    chk("R10 second result after step is full", res_val[3], expv(13, 0, 0));
  endtask

  task automatic t_noise();
    dens = 5; chopmode = 1; noise = 1;
    wr_rate(13);
    wait_res(3);
    for (int i = 0; i < 3; i++)
      chk("R9 idle-cycle inputs ignored", res_val[i], expv(13, 5, 5));
    chk("R9 rate data ignored without write", res_tick[2], 48 * 13 + 2 * 24 * 13);
    chk("R8 settled stays high", longint'(settled), 1);
    noise = 0;
  endtask

  initial begin
    fork
      driver();
      monitor();
    join_none
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clamp();
        t_max();
        t_density(6);
        t_density(1);
        t_density(4);
        t_offset(8);
        t_offset(3);
        t_step();
        t_noise();
        wr_rate(69);
      end
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule